// File: doc/BRIEF.md
# Peripheral Slot ROM Select Logic

This block sits between the CPU address bus and the I/O expansion area of an 8-bit machine. It covers the $C100-$CFFF range, which holds seven 256-byte card pages and one shared 2 KB expansion window. For each bus access it decides whether the built-in firmware ROM answers or a peripheral card does. When a card answers, the block drives a one-hot slot select and the card-relative offset. For the shared window it also drives the expansion strobe enable.

Three mode flags control the routing:
- an internal-override flag, which gives the whole range to the firmware ROM;
- a slot-3 card flag, which chooses between the firmware and the slot-3 card for the $C3xx page;
- a window-capture latch, which gives the $C800 window to the firmware.

Software sets and clears the first two flags through address-only write switches. The latch has no switch. It is set by a side effect of touching the $C3xx page and cleared by touching $CFFF. The block also remembers which card owns the window, from the last page access that a card served. Two status addresses return the software-visible flags in bit 7.

All outputs are combinational from the current access and the registered state. Every state update lands on the clock edge that ends the access, so the access itself is decoded with the old state.

Top module: `slot_rom_sel`

## Requirements
- R1: After reset, the override flag, the slot-3 flag, the window latch and the window owner are all 0, so both status reads return 0x00 and a window access selects nothing.
- R2: A write to $C006 or $C007 loads the override flag from address bit 0. A write to $C00A or $C00B loads the slot-3 flag from address bit 0. Reads of these four addresses change nothing.
- R3: A read of $C015 raises stat_hit_o and returns the override flag in bit 7. A read of $C017 raises stat_hit_o and returns the slot-3 flag in bit 7. The other data bits are 0. No other access raises stat_hit_o, and stat_data_o is then 0x00.
- R4: While the override flag is 1, every access in $C100-$C7FF and $C800-$CFFE raises int_rom_sel_o only. No slot is selected and the strobe enable stays low.
- R5: While the override flag is 0, an access to page $Cn00 (n = 1, 2, 4..7) raises bit n of slot_sel_o and puts address bits 7:0 on card_ofs_o, with the upper bits 0.
- R6: While the override flag is 0, the $C3xx page goes to the internal ROM when the slot-3 flag is 0, and to slot 3 when the slot-3 flag is 1.
- R7: A read or write of $C300-$C3FF while the slot-3 flag is 0 sets the window latch. The same access with the slot-3 flag at 1 leaves the latch unchanged.
- R8: Any read or write of $CFFF clears the window latch and the window owner. The $CFFF access itself selects neither the ROM nor a card.
- R9: An access to $C800-$CFFE goes to the internal ROM when the override flag or the window latch is 1. Otherwise it raises the owner's slot bit and strobe_en_o, with address bits 10:0 on card_ofs_o. With owner 0, nothing responds.
- R10: The window owner is loaded with n on each page access that card n serves. Page accesses served by the internal ROM leave the owner unchanged.
- R11: A flag change caused by an access first affects the decode of the next access.
- R12: With acc_valid_i low, or with an address outside $C100-$CFFF, no select or strobe is raised and no state changes. Switch and status addresses are the only exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | A bus access is present this cycle |
| acc_we_i | input | 1 | Access is a write |
| acc_addr_i | input | 16 | CPU address |
| int_rom_sel_o | output | 1 | Internal firmware ROM answers |
| slot_sel_o | output | 8 | One-hot card select, bit n = slot n |
| strobe_en_o | output | 1 | Expansion window strobe to the owning card |
| card_ofs_o | output | 11 | Card-relative offset |
| stat_hit_o | output | 1 | This block drives read data |
| stat_data_o | output | 8 | Status byte |

## Verification
On every cycle, the assertions check these structural rules:
- slot_sel_o is one-hot or zero;
- the ROM select and the card selects never overlap;
- the strobe never fires without a card;
- $CFFF never selects anything;
- the override flag forces internal routing;
- the latch and switch updates land one edge after their trigger.

Only the bench's ordered scenarios can show the behaviours that need history. These are window ownership carried across many accesses, the owner surviving ROM-served page accesses, the latch set through the $C3xx page and later released through $CFFF, and the one-access lag of each flag change.

// File: rtl/slot_rom_pkg.sv
package slot_rom_pkg;
  localparam int ADDR_W     = 16;
  localparam int SLOT_W     = 3;
  localparam int NUM_SLOTS  = 1 << SLOT_W;
  localparam int PAGE_OFS_W = 8;
  localparam int WIN_OFS_W  = 11;
  localparam int DATA_W     = 8;
  localparam int HI_W       = ADDR_W - WIN_OFS_W;

  localparam logic [ADDR_W-1:0] PAGE_BASE  = 16'hC000;
  localparam logic [ADDR_W-1:0] WIN_BASE   = 16'hC800;
  localparam logic [ADDR_W-1:0] WIN_OFF_A  = 16'hCFFF;
  localparam logic [ADDR_W-1:0] SW_OVR_A   = 16'hC006;
  localparam logic [ADDR_W-1:0] SW_S3_A    = 16'hC00A;
  localparam logic [ADDR_W-1:0] ST_OVR_A   = 16'hC015;
  localparam logic [ADDR_W-1:0] ST_S3_A    = 16'hC017;
  localparam logic [SLOT_W-1:0] S3_SLOT    = 3'd3;

  typedef enum logic [1:0] {
    RGN_NONE    = 2'd0,
    RGN_PAGE    = 2'd1,
    RGN_WIN     = 2'd2,
    RGN_WIN_OFF = 2'd3
  } region_e;

  typedef struct packed {
    region_e           rgn;
    logic [SLOT_W-1:0] slot;
    logic              ovr_wr;
    logic              s3_wr;
    logic              new_val;
    logic              st_ovr;
    logic              st_s3;
  } acc_dec_t;
endpackage

// File: rtl/slot_addr_decode.sv
module slot_addr_decode
  import slot_rom_pkg::*;
(
  input  logic              valid_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output acc_dec_t          dec_o
);
  logic [HI_W-1:0]   hi;
  logic [SLOT_W-1:0] pg;

  assign hi = addr_i[ADDR_W-1:WIN_OFS_W];
  assign pg = addr_i[PAGE_OFS_W +: SLOT_W];

  always_comb begin
    dec_o     = '0;
    dec_o.rgn = RGN_NONE;
    if (valid_i) begin
      if (hi == PAGE_BASE[ADDR_W-1:WIN_OFS_W] && pg != '0) begin
        dec_o.rgn  = RGN_PAGE;
        dec_o.slot = pg;
      end else if (addr_i == WIN_OFF_A) begin
        dec_o.rgn = RGN_WIN_OFF;
      end else if (hi == WIN_BASE[ADDR_W-1:WIN_OFS_W]) begin
        dec_o.rgn = RGN_WIN;
      end
      dec_o.ovr_wr  = we_i && (addr_i[ADDR_W-1:1] == SW_OVR_A[ADDR_W-1:1]);
      dec_o.s3_wr   = we_i && (addr_i[ADDR_W-1:1] == SW_S3_A[ADDR_W-1:1]);
      dec_o.new_val = addr_i[0];
      dec_o.st_ovr  = !we_i && (addr_i == ST_OVR_A);
      dec_o.st_s3   = !we_i && (addr_i == ST_S3_A);
    end
  end
endmodule

// File: rtl/slot_mode_regs.sv
module slot_mode_regs
  import slot_rom_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  region_e           rgn_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              ovr_wr_i,
  input  logic              s3_wr_i,
  input  logic              new_val_i,
  output logic              ovr_o,
  output logic              s3_o,
  output logic              c8_o
);
  logic ovr_q, s3_q, c8_q;
  logic c8_set, c8_clr;

  assign c8_set = (rgn_i == RGN_PAGE) && (slot_i == S3_SLOT) && !s3_q;
  assign c8_clr = (rgn_i == RGN_WIN_OFF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_q <= 1'b0;
      s3_q  <= 1'b0;
      c8_q  <= 1'b0;
    end else begin
      if (ovr_wr_i) ovr_q <= new_val_i;
      if (s3_wr_i)  s3_q  <= new_val_i;
      if (c8_clr)      c8_q <= 1'b0;
      else if (c8_set) c8_q <= 1'b1;
    end
  end

  assign ovr_o = ovr_q;
  assign s3_o  = s3_q;
  assign c8_o  = c8_q;

  // R2
  ovr_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_wr_i |=> (ovr_q == $past(new_val_i))) else $error("ovr_wr_chk");
  // R2
  s3_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s3_wr_i |=> (s3_q == $past(new_val_i))) else $error("s3_wr_chk");
  // R12
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ovr_wr_i && !s3_wr_i) |=> ($stable(ovr_q) && $stable(s3_q))) else $error("flag_hold_chk");
  // R7
  c8_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rgn_i == RGN_PAGE) && (slot_i == S3_SLOT) && !s3_o) |=> c8_q) else $error("c8_set_chk");
  // R8
  c8_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rgn_i == RGN_WIN_OFF) |=> !c8_q) else $error("c8_clr_chk");
endmodule

// File: rtl/slot_router.sv
module slot_router
  import slot_rom_pkg::*;
#(
  parameter int N_SLOTS = NUM_SLOTS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  region_e              rgn_i,
  input  logic [SLOT_W-1:0]    slot_i,
  input  logic [WIN_OFS_W-1:0] addr_i,
  input  logic                 ovr_i,
  input  logic                 s3_i,
  input  logic                 c8_i,
  output logic                 int_sel_o,
  output logic [N_SLOTS-1:0]   slot_sel_o,
  output logic                 stb_o,
  output logic [WIN_OFS_W-1:0] ofs_o
);
  localparam int PAD_W = WIN_OFS_W - PAGE_OFS_W;

  logic [SLOT_W-1:0] owner_q;
  logic [SLOT_W-1:0] card_num;
  logic              card_hit;

  always_comb begin
    int_sel_o = 1'b0;
    card_hit  = 1'b0;
    card_num  = '0;
    stb_o     = 1'b0;
    ofs_o     = '0;
    unique case (rgn_i)
      RGN_PAGE: begin
        if (ovr_i || (slot_i == S3_SLOT && !s3_i)) begin
          int_sel_o = 1'b1;
        end else begin
          card_hit = 1'b1;
          card_num = slot_i;
          ofs_o    = {{PAD_W{1'b0}}, addr_i[PAGE_OFS_W-1:0]};
        end
      end
      RGN_WIN: begin
        if (ovr_i || c8_i) begin
          int_sel_o = 1'b1;
        end else if (owner_q != '0) begin
          card_hit = 1'b1;
          card_num = owner_q;
          stb_o    = 1'b1;
          ofs_o    = addr_i;
        end
      end
      default: ;
    endcase
  end

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_sel
    assign slot_sel_o[i] = card_hit && (card_num == SLOT_W'(i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                owner_q <= '0;
    else if (rgn_i == RGN_WIN_OFF)              owner_q <= '0;
    else if (rgn_i == RGN_PAGE && !int_sel_o)   owner_q <= slot_i;
  end

  // R5
  sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(slot_sel_o)) else $error("sel_onehot_chk");
  // R4
  ovr_int_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_i && (rgn_i == RGN_PAGE || rgn_i == RGN_WIN)) |-> (int_sel_o && slot_sel_o == '0))
    else $error("ovr_int_chk");
  // R9
  stb_card_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o |-> (!int_sel_o && $countones(slot_sel_o) == 1)) else $error("stb_card_chk");
  // R8
  off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rgn_i == RGN_WIN_OFF) |-> (!int_sel_o && slot_sel_o == '0 && !stb_o)) else $error("off_quiet_chk");
  // R10
  owner_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rgn_i == RGN_PAGE && slot_sel_o != '0) |=> (owner_q == $past(slot_i))) else $error("owner_load_chk");
endmodule

// File: rtl/slot_rom_sel.sv
module slot_rom_sel
  import slot_rom_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 acc_valid_i,
  input  logic                 acc_we_i,
  input  logic [ADDR_W-1:0]    acc_addr_i,
  output logic                 int_rom_sel_o,
  output logic [NUM_SLOTS-1:0] slot_sel_o,
  output logic                 strobe_en_o,
  output logic [WIN_OFS_W-1:0] card_ofs_o,
  output logic                 stat_hit_o,
  output logic [DATA_W-1:0]    stat_data_o
);
  acc_dec_t dec;
  logic     ovr, s3, c8;

  slot_addr_decode u_dec (
    .valid_i (acc_valid_i),
    .we_i    (acc_we_i),
    .addr_i  (acc_addr_i),
    .dec_o   (dec)
  );

  slot_mode_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rgn_i     (dec.rgn),
    .slot_i    (dec.slot),
    .ovr_wr_i  (dec.ovr_wr),
    .s3_wr_i   (dec.s3_wr),
    .new_val_i (dec.new_val),
    .ovr_o     (ovr),
    .s3_o      (s3),
    .c8_o      (c8)
  );

  slot_router #(.N_SLOTS(NUM_SLOTS)) u_route (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rgn_i      (dec.rgn),
    .slot_i     (dec.slot),
    .addr_i     (acc_addr_i[WIN_OFS_W-1:0]),
    .ovr_i      (ovr),
    .s3_i       (s3),
    .c8_i       (c8),
    .int_sel_o  (int_rom_sel_o),
    .slot_sel_o (slot_sel_o),
    .stb_o      (strobe_en_o),
    .ofs_o      (card_ofs_o)
  );

  assign stat_hit_o  = dec.st_ovr || dec.st_s3;
  assign stat_data_o = {(dec.st_ovr && ovr) || (dec.st_s3 && s3), {(DATA_W-1){1'b0}}};

  // R3
  stat_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stat_hit_o |-> stat_data_o == '0) && (stat_data_o[DATA_W-2:0] == '0)) else $error("stat_idle_chk");
  // R12
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |-> (!int_rom_sel_o && slot_sel_o == '0 && !strobe_en_o && !stat_hit_o))
    else $error("idle_quiet_chk");
endmodule

// File: tb/slot_rom_sel_test.sv
`timescale 1ns/1ps
module slot_rom_sel_test;
  localparam int VW = 52;
  localparam int NV = 33;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid = 1'b0;
  logic        we = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic        int_sel;
  logic [7:0]  sel;
  logic        stb;
  logic [10:0] ofs;
  logic        hit;
  logic [7:0]  rd;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  slot_rom_sel uut (
    .clk_i (clk), .rst_ni (rst_ni), .acc_valid_i (valid), .acc_we_i (we),
    .acc_addr_i (addr), .int_rom_sel_o (int_sel), .slot_sel_o (sel),
    .strobe_en_o (stb), .card_ofs_o (ofs), .stat_hit_o (hit), .stat_data_o (rd)
  );

  // {req, valid, we, addr, int, sel, stb, ofs, hit, rd}
  localparam logic [VW-1:0] VEC [NV] = '{
    {4'd12,1'b0,1'b0,16'hC300, 1'b0,8'h00,1'b0,11'h000,1'b0,8'h00}, // R12 idle
    {4'd3, 1'b1,1'b0,16'hC015, 1'b0,8'h00,1'b0,11'h000,1'b1,8'h00}, // R3 R1
    {4'd3, 1'b1,1'b0,16'hC017, 1'b0,8'h00,1'b0,11'h000,1'b1,8'h00}, // R3
    {4'd9, 1'b1,1'b0,16'hC800, 1'b0,8'h00,1'b0,11'h000,1'b0,8'h00}, // R9 no owner
    {4'd5, 1'b1,1'b0,16'hC105, 1'b0,8'h02,1'b0,11'h005,1'b0,8'h00}, // R5
    {4'd9, 1'b1,1'b0,16'hCABC, 1'b0,8'h02,1'b1,11'h2BC,1'b0,8'h00}, // R9
    {4'd5, 1'b1,1'b0,16'hC6FF, 1'b0,8'h40,1'b0,11'h0FF,1'b0,8'h00}, // R5
    {4'd10,1'b1,1'b1,16'hC800, 1'b0,8'h40,1'b1,11'h000,1'b0,8'h00}, // R10
    {4'd6, 1'b1,1'b0,16'hC310, 1'b1,8'h00,1'b0,11'h000,1'b0,8'h00}, // R6
    {4'd11,1'b1,1'b0,16'hC900, 1'b1,8'h00,1'b0,11'h000,1'b0,8'h00}, // R11 R7
    {4'd8, 1'b1,1'b0,16'hCFFF, 1'b0,8'h00,1'b0,11'h000,1'b0,8'h00}, // R8
    {4'd8, 1'b1,1'b0,16'hC900, 1'b0,8'h00,1'b0,11'h000,1'b0,8'h00}, // R8
    {4'd2, 1'b1,1'b1,16'hC00B, 1'b0,8'h00,1'b0,11'h000,1'b0,8'h00}, // R2
    {4'd3, 1'b1,1'b0,16'hC017, 1'b0,8'h00,1'b0,11'h000,1'b1,8'h80}, // R3
    {4'd6, 1'b1,1'b0,16'hC3A0, 1'b0,8'h08,1'b0,11'h0A0,1'b0,8'h00}, // R6
    {4'd7, 1'b1,1'b0,16'hC801, 1'b0,8'h08,1'b1,11'h001,1'b0,8'h00}, // R7
    {4'd2, 1'b1,1'b1,16'hC007, 1'b0,8'h00,1'b0,11'h000,1'b0,8'h00}, // R2
    {4'd3, 1'b1,1'b0,16'hC015, 1'b0,8'h00,1'b0,11'h000,1'b1,8'h80}, // R3
    {4'd4, 1'b1,1'b0,16'hC200, 1'b1,8'h00,1'b0,11'h000,1'b0,8'h00}, // R4
    {4'd4, 1'b1,1'b0,16'hCFFE, 1'b1,8'h00,1'b0,11'h000,1'b0,8'h00}, // R4
    {4'd3, 1'b1,1'b0,16'hC017, 1'b0,8'h00,1'b0,11'h000,1'b1,8'h80}, // R3
    {4'd2, 1'b1,1'b1,16'hC006, 1'b0,8'h00,1'b0,11'h000,1'b0,8'h00}, // R2
    {4'd10,1'b1,1'b0,16'hC800, 1'b0,8'h08,1'b1,11'h000,1'b0,8'h00}, // R10
    {4'd2, 1'b1,1'b0,16'hC007, 1'b0,8'h00,1'b0,11'h000,1'b0,8'h00}, // R2 read
    {4'd2, 1'b1,1'b0,16'hC015, 1'b0,8'h00,1'b0,11'h000,1'b1,8'h00}, // R2
    {4'd2, 1'b1,1'b1,16'hC00A, 1'b0,8'h00,1'b0,11'h000,1'b0,8'h00}, // R2
    {4'd7, 1'b1,1'b1,16'hC3FF, 1'b1,8'h00,1'b0,11'h000,1'b0,8'h00}, // R7
    {4'd11,1'b1,1'b0,16'hC800, 1'b1,8'h00,1'b0,11'h000,1'b0,8'h00}, // R11
    {4'd8, 1'b1,1'b1,16'hCFFF, 1'b0,8'h00,1'b0,11'h000,1'b0,8'h00}, // R8
    {4'd12,1'b1,1'b0,16'hD000, 1'b0,8'h00,1'b0,11'h000,1'b0,8'h00}, // R12
    {4'd12,1'b1,1'b0,16'hC0FF, 1'b0,8'h00,1'b0,11'h000,1'b0,8'h00}, // R12
    {4'd3, 1'b1,1'b0,16'hC016, 1'b0,8'h00,1'b0,11'h000,1'b0,8'h00}, // R3
    {4'd8, 1'b1,1'b0,16'hC800, 1'b0,8'h00,1'b0,11'h000,1'b0,8'h00}  // R8
  };

  task automatic step(input int req, input logic v, input logic w,
                      input logic [15:0] a, input logic [29:0] exp);
    logic [29:0] act;
    @(negedge clk);
    valid = v; we = w; addr = a;
    #2;
    act = {int_sel, sel, stb, ofs, hit, rd};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d addr %h: act %h exp %h", req, a, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 status reads during reset
    step(1, 1'b1, 1'b0, 16'hC015, {1'b0,8'h00,1'b0,11'h000,1'b1,8'h00});
    @(negedge clk);
    rst_ni = 1'b1;
    valid = 1'b0;
    for (int i = 0; i < NV; i++) begin
      step(int'(VEC[i][51:48]), VEC[i][47], VEC[i][46], VEC[i][45:30], VEC[i][29:0]);
    end
    // R1 reset clears everything set beforehand
    step(2, 1'b1, 1'b1, 16'hC00B, 30'h0);
    step(5, 1'b1, 1'b0, 16'hC500, {1'b0,8'h20,1'b0,11'h000,1'b0,8'h00});
    step(2, 1'b1, 1'b1, 16'hC007, 30'h0);
    @(negedge clk);
    valid = 1'b0;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    step(1, 1'b1, 1'b0, 16'hC015, {1'b0,8'h00,1'b0,11'h000,1'b1,8'h00}); // R1
    step(1, 1'b1, 1'b0, 16'hC017, {1'b0,8'h00,1'b0,11'h000,1'b1,8'h00}); // R1
    step(1, 1'b1, 1'b0, 16'hC800, 30'h0);                               // R1 owner cleared
    step(1, 1'b1, 1'b0, 16'hC900, 30'h0);                               // R1 latch clear (C3 not touched)
    step(6, 1'b1, 1'b0, 16'hC300, {1'b1,8'h00,1'b0,11'h000,1'b0,8'h00}); // R6 slot-3 flag reset
    @(negedge clk);
    valid = 1'b0;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: act timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule